// File: doc/BRIEF.md
# Multi-cycle processor control sequencer

This block is the hardwired control unit of a 32-bit processor that runs each instruction over several clock cycles. One memory and one ALU are shared between those cycles. Every cycle it reads the 6-bit opcode held in the instruction register and the ALU overflow flag. It then drives the select, enable and write strobes of the datapath, so that instruction fetch, register read, execution, memory access and register write-back take place in turn.

The number of cycles depends on the instruction class:

| Class | Cycles |
|---|---|
| Load | 5 |
| Register-register arithmetic | 4 |
| Store | 4 |
| Conditional branch | 3 |
| Jump | 3 |

Two faults are handled. An opcode the block does not recognise is one fault. Overflow during register-register arithmetic is the other. For either fault, one exception cycle does three things:
- It makes the ALU compute the faulting instruction's address, which is the current PC minus 4.
- It loads that address into the fault address register, together with a cause code.
- It steers the PC to the fixed vector C0000000h.

The datapath is not part of the block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs carry the fetch control word. The reset is asynchronous.
- R2: The fetch cycle asserts mem_rd_o, instr_we_o and pc_we_o, with mem_addr_sel_o=0, alu_a_sel_o=0, alu_b_sel_o=01, alu_mode_o=00 (add) and pc_sel_o=00. All other strobes are 0.
- R3: The cycle after fetch is decode: alu_b_sel_o=11, alu_a_sel_o=0, alu_mode_o=00, and no write strobe. This cycle dispatches on the opcode. The recognised opcodes are register-register 000000, load 100011, store 101011, branch-if-equal 000100 and jump 000010.
- R4: Register-register execution takes 4 cycles. The execute cycle uses alu_a_sel_o=1, alu_b_sel_o=00 and alu_mode_o=10 (function field). The completion cycle asserts rf_we_o and rf_dst_rd_o, with wb_sel_mem_o=0.
- R5: A load takes 5 cycles. The address cycle uses alu_a_sel_o=1, alu_b_sel_o=10 and alu_mode_o=00. The memory cycle asserts mem_rd_o with mem_addr_sel_o=1. The write-back cycle asserts rf_we_o and wb_sel_mem_o=1, with rf_dst_rd_o=0.
- R6: A store takes 4 cycles. The address cycle is the same as for a load. It is followed by a cycle that asserts mem_wr_o with mem_addr_sel_o=1.
- R7: A branch takes 3 cycles. Its third cycle asserts pc_we_cond_o with pc_sel_o=01, alu_mode_o=01 (subtract), alu_a_sel_o=1 and alu_b_sel_o=00. pc_we_o stays 0.
- R8: A jump takes 3 cycles. Its third cycle asserts pc_we_o with pc_sel_o=10, and no other strobe.
- R9: After decode of an unrecognised opcode, an exception cycle follows. It asserts fault_pc_we_o, fault_code_we_o and pc_we_o, with pc_sel_o=11 (vector), alu_mode_o=01, alu_a_sel_o=0, alu_b_sel_o=01 and fault_code_o=0. The instruction takes 3 cycles.
- R10: If overflow_i is 1 in the register-register execute cycle, the next cycle is the exception cycle of R9 with fault_code_o=1, and rf_we_o stays 0.
- R11: overflow_i has no effect in any other cycle or instruction class.
- R12: After every completion cycle and every exception cycle, the next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| overflow_i | input | 1 | ALU signed overflow flag |
| pc_we_o | output | 1 | Unconditional PC write |
| pc_we_cond_o | output | 1 | PC write when the ALU zero flag is set |
| mem_addr_sel_o | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| instr_we_o | output | 1 | Instruction register load |
| wb_sel_mem_o | output | 1 | Register write data: 0 = ALU result, 1 = memory data register |
| pc_sel_o | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 vector |
| alu_mode_o | output | 2 | 00 add, 01 subtract, 10 function field |
| alu_a_sel_o | output | 1 | ALU A: 0 = PC, 1 = register A |
| alu_b_sel_o | output | 2 | ALU B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| rf_we_o | output | 1 | Register file write |
| rf_dst_rd_o | output | 1 | Destination: 0 = rt field, 1 = rd field |
| fault_pc_we_o | output | 1 | Fault address register load |
| fault_code_we_o | output | 1 | Cause register load |
| fault_code_o | output | 1 | Cause: 0 undefined opcode, 1 overflow |

## Verification
The assertions check these behaviours on every cycle:
- Fetch always increments the PC and reads memory at the PC.
- Decode always follows fetch.
- Memory is never read and written in the same cycle.
- Every exception cycle redirects the PC to the vector and is followed by fetch.
- An overflow in the register-register execute cycle raises an overflow exception with no register write.
- An unrecognised opcode at decode leads to an undefined-opcode exception.

Only the bench's scenarios show the rest:
- The full control word in each cycle of each class.
- The exact cycle counts.
- That overflow is ignored on loads, stores, branches and jumps.
- That a reset in the middle of an instruction forces fetch at once.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPCODE_W = 6;
  localparam int STATE_W  = 4;

  localparam logic [OPCODE_W-1:0] OP_RTYPE  = 6'b000000;
  localparam logic [OPCODE_W-1:0] OP_LOAD   = 6'b100011;
  localparam logic [OPCODE_W-1:0] OP_STORE  = 6'b101011;
  localparam logic [OPCODE_W-1:0] OP_BRANCH = 6'b000100;
  localparam logic [OPCODE_W-1:0] OP_JUMP   = 6'b000010;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH    = 4'd0,
    ST_DECODE   = 4'd1,
    ST_MEM_ADDR = 4'd2,
    ST_MEM_RD   = 4'd3,
    ST_LOAD_WB  = 4'd4,
    ST_MEM_WR   = 4'd5,
    ST_R_EXEC   = 4'd6,
    ST_R_DONE   = 4'd7,
    ST_BRANCH   = 4'd8,
    ST_JUMP     = 4'd9,
    ST_EXC_UND  = 4'd10,
    ST_EXC_OVF  = 4'd11
  } state_e;

  typedef enum logic [2:0] {
    CL_RTYPE,
    CL_LOAD,
    CL_STORE,
    CL_BRANCH,
    CL_JUMP,
    CL_UNDEF
  } op_class_e;

  // ALU mode encodings
  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  // PC source encodings
  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_ALUREG = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;
  localparam logic [1:0] PCS_VECTOR = 2'b11;

  // ALU B source encodings
  localparam logic [1:0] BSRC_REG  = 2'b00;
  localparam logic [1:0] BSRC_FOUR = 2'b01;
  localparam logic [1:0] BSRC_IMM  = 2'b10;
  localparam logic [1:0] BSRC_IMMS = 2'b11;

  localparam logic CAUSE_UNDEF = 1'b0;
  localparam logic CAUSE_OVF   = 1'b1;

  typedef struct packed {
    logic       pc_we;
    logic       pc_we_cond;
    logic       mem_addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       instr_we;
    logic       wb_sel_mem;
    logic [1:0] pc_sel;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_we;
    logic       rf_dst_rd;
    logic       fault_pc_we;
    logic       fault_code_we;
    logic       fault_code;
  } ctrl_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
  import mc_ctrl_pkg::*;
(
  input  logic [OPCODE_W-1:0] opcode_i,
  output op_class_e           class_o
);

  always_comb begin
    unique case (opcode_i)
      OP_RTYPE:  class_o = CL_RTYPE;
      OP_LOAD:   class_o = CL_LOAD;
      OP_STORE:  class_o = CL_STORE;
      OP_BRANCH: class_o = CL_BRANCH;
      OP_JUMP:   class_o = CL_JUMP;
      default:   class_o = CL_UNDEF;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
(
  input  state_e    state_i,
  input  op_class_e class_i,
  input  logic      overflow_i,
  output state_e    next_o
);

  always_comb begin
    next_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH: next_o = ST_DECODE;
      ST_DECODE: begin
        unique case (class_i)
          CL_RTYPE:           next_o = ST_R_EXEC;
          CL_LOAD, CL_STORE:  next_o = ST_MEM_ADDR;
          CL_BRANCH:          next_o = ST_BRANCH;
          CL_JUMP:            next_o = ST_JUMP;
          default:            next_o = ST_EXC_UND;
        endcase
      end
      ST_MEM_ADDR: next_o = (class_i == CL_LOAD) ? ST_MEM_RD : ST_MEM_WR;
      ST_MEM_RD:   next_o = ST_LOAD_WB;
      // overflow only matters while register-register arithmetic executes
      ST_R_EXEC:   next_o = overflow_i ? ST_EXC_OVF : ST_R_DONE;
      default:     next_o = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.instr_we  = 1'b1;
        ctrl_o.pc_we     = 1'b1;
        ctrl_o.pc_sel    = PCS_ALU;
        ctrl_o.alu_mode  = ALU_ADD;
        ctrl_o.alu_b_sel = BSRC_FOUR;
      end
      ST_DECODE: begin
        ctrl_o.alu_mode  = ALU_ADD;
        ctrl_o.alu_b_sel = BSRC_IMMS;
      end
      ST_MEM_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSRC_IMM;
        ctrl_o.alu_mode  = ALU_ADD;
      end
      ST_MEM_RD: begin
        ctrl_o.mem_rd       = 1'b1;
        ctrl_o.mem_addr_sel = 1'b1;
      end
      ST_LOAD_WB: begin
        ctrl_o.rf_we      = 1'b1;
        ctrl_o.wb_sel_mem = 1'b1;
      end
      ST_MEM_WR: begin
        ctrl_o.mem_wr       = 1'b1;
        ctrl_o.mem_addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSRC_REG;
        ctrl_o.alu_mode  = ALU_FUNC;
      end
      ST_R_DONE: begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.rf_dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = BSRC_REG;
        ctrl_o.alu_mode   = ALU_SUB;
        ctrl_o.pc_we_cond = 1'b1;
        ctrl_o.pc_sel     = PCS_ALUREG;
      end
      ST_JUMP: begin
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pc_sel = PCS_JUMP;
      end
      ST_EXC_UND, ST_EXC_OVF: begin
        // ALU forms PC-4: address of the faulting instruction
        ctrl_o.alu_mode      = ALU_SUB;
        ctrl_o.alu_b_sel     = BSRC_FOUR;
        ctrl_o.fault_pc_we   = 1'b1;
        ctrl_o.fault_code_we = 1'b1;
        ctrl_o.fault_code    = (state_i == ST_EXC_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
        ctrl_o.pc_we         = 1'b1;
        ctrl_o.pc_sel        = PCS_VECTOR;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OPCODE_W-1:0] opcode_i,
  input  logic                overflow_i,
  output logic                pc_we_o,
  output logic                pc_we_cond_o,
  output logic                mem_addr_sel_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic                instr_we_o,
  output logic                wb_sel_mem_o,
  output logic [1:0]          pc_sel_o,
  output logic [1:0]          alu_mode_o,
  output logic                alu_a_sel_o,
  output logic [1:0]          alu_b_sel_o,
  output logic                rf_we_o,
  output logic                rf_dst_rd_o,
  output logic                fault_pc_we_o,
  output logic                fault_code_we_o,
  output logic                fault_code_o
);

  state_e    state_q, state_d;
  op_class_e op_class;
  ctrl_t     ctrl;

  mc_op_class u_class (
    .opcode_i (opcode_i),
    .class_o  (op_class)
  );

  mc_ctrl_next u_next (
    .state_i    (state_q),
    .class_i    (op_class),
    .overflow_i (overflow_i),
    .next_o     (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  mc_ctrl_out u_out (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  assign pc_we_o         = ctrl.pc_we;
  assign pc_we_cond_o    = ctrl.pc_we_cond;
  assign mem_addr_sel_o  = ctrl.mem_addr_sel;
  assign mem_rd_o        = ctrl.mem_rd;
  assign mem_wr_o        = ctrl.mem_wr;
  assign instr_we_o      = ctrl.instr_we;
  assign wb_sel_mem_o    = ctrl.wb_sel_mem;
  assign pc_sel_o        = ctrl.pc_sel;
  assign alu_mode_o      = ctrl.alu_mode;
  assign alu_a_sel_o     = ctrl.alu_a_sel;
  assign alu_b_sel_o     = ctrl.alu_b_sel;
  assign rf_we_o         = ctrl.rf_we;
  assign rf_dst_rd_o     = ctrl.rf_dst_rd;
  assign fault_pc_we_o   = ctrl.fault_pc_we;
  assign fault_code_we_o = ctrl.fault_code_we;
  assign fault_code_o    = ctrl.fault_code;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk
  import mc_ctrl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [OPCODE_W-1:0] opcode_i,
  input logic                overflow_i,
  input logic                pc_we_o,
  input logic                pc_we_cond_o,
  input logic                mem_addr_sel_o,
  input logic                mem_rd_o,
  input logic                mem_wr_o,
  input logic                instr_we_o,
  input logic                wb_sel_mem_o,
  input logic [1:0]          pc_sel_o,
  input logic [1:0]          alu_mode_o,
  input logic                alu_a_sel_o,
  input logic [1:0]          alu_b_sel_o,
  input logic                rf_we_o,
  input logic                rf_dst_rd_o,
  input logic                fault_pc_we_o,
  input logic                fault_code_we_o,
  input logic                fault_code_o
);

  logic known_op;
  assign known_op = (opcode_i == OP_RTYPE) || (opcode_i == OP_LOAD) ||
                    (opcode_i == OP_STORE) || (opcode_i == OP_BRANCH) ||
                    (opcode_i == OP_JUMP);

  logic decode_cyc, rexec_cyc;
  assign decode_cyc = (alu_b_sel_o == BSRC_IMMS) && !alu_a_sel_o;
  assign rexec_cyc  = (alu_mode_o == ALU_FUNC);

  assert_fetch_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_we_o |-> (pc_we_o && mem_rd_o && !mem_addr_sel_o && !pc_we_cond_o));

  assert_decode_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_we_o |=> (decode_cyc && !pc_we_o && !rf_we_o && !mem_wr_o));

  assert_mem_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_undef_trap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decode_cyc && !known_op) |=> (fault_pc_we_o && fault_code_we_o && !fault_code_o));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rexec_cyc && overflow_i) |=> (!rf_we_o && fault_pc_we_o && fault_code_o));

  assert_vector_redirect_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pc_we_o |-> (pc_we_o && pc_sel_o == PCS_VECTOR && fault_code_we_o && !wb_sel_mem_o));

  assert_exc_then_fetch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pc_we_o |=> (instr_we_o && !rf_dst_rd_o));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (.*);

// File: tb/mc_ctrl_fsm_test.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'b0;
  logic       overflow_i = 1'b0;
  logic pc_we_o, pc_we_cond_o, mem_addr_sel_o, mem_rd_o, mem_wr_o, instr_we_o, wb_sel_mem_o;
  logic [1:0] pc_sel_o, alu_mode_o, alu_b_sel_o;
  logic alu_a_sel_o, rf_we_o, rf_dst_rd_o, fault_pc_we_o, fault_code_we_o, fault_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  mc_ctrl_fsm uut (.*);

  // word layout: pc_we pc_we_cond addr_sel rd wr instr_we wb_mem | pc_sel | alu_mode | a_sel | b_sel | rf_we dst_rd fpc fcode_we fcode
  localparam logic [18:0] W_Z     = 19'b0;
  localparam logic [18:0] W_FETCH = 19'b1001010_00_00_0_01_00000;
  localparam logic [18:0] W_DEC   = 19'b0000000_00_00_0_11_00000;
  localparam logic [18:0] W_MADDR = 19'b0000000_00_00_1_10_00000;
  localparam logic [18:0] W_MRD   = 19'b0011000_00_00_0_00_00000;
  localparam logic [18:0] W_LWB   = 19'b0000001_00_00_0_00_10000;
  localparam logic [18:0] W_MWR   = 19'b0010100_00_00_0_00_00000;
  localparam logic [18:0] W_REX   = 19'b0000000_00_10_1_00_00000;
  localparam logic [18:0] W_RDN   = 19'b0000000_00_00_0_00_11000;
  localparam logic [18:0] W_BEQ   = 19'b0100000_01_01_1_00_00000;
  localparam logic [18:0] W_JMP   = 19'b1000000_10_00_0_00_00000;
  localparam logic [18:0] W_EXU   = 19'b1000000_11_01_0_01_00110;
  localparam logic [18:0] W_EXO   = 19'b1000000_11_01_0_01_00111;

  typedef struct packed {
    logic [5:0]       op;
    logic             ovf;
    logic [2:0]       len;
    logic [4:0][18:0] w;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t TBL [NVEC] = '{
    '{6'b000000, 1'b0, 3'd4, {W_Z,   W_RDN, W_REX,   W_DEC, W_FETCH}},
    '{6'b100011, 1'b0, 3'd5, {W_LWB, W_MRD, W_MADDR, W_DEC, W_FETCH}},
    '{6'b101011, 1'b0, 3'd4, {W_Z,   W_MWR, W_MADDR, W_DEC, W_FETCH}},
    '{6'b000100, 1'b0, 3'd3, {W_Z,   W_Z,   W_BEQ,   W_DEC, W_FETCH}},
    '{6'b000010, 1'b0, 3'd3, {W_Z,   W_Z,   W_JMP,   W_DEC, W_FETCH}},
    '{6'b111111, 1'b0, 3'd3, {W_Z,   W_Z,   W_EXU,   W_DEC, W_FETCH}},
    '{6'b000000, 1'b1, 3'd4, {W_Z,   W_EXO, W_REX,   W_DEC, W_FETCH}},
    '{6'b100011, 1'b1, 3'd5, {W_LWB, W_MRD, W_MADDR, W_DEC, W_FETCH}},
    '{6'b101011, 1'b1, 3'd4, {W_Z,   W_MWR, W_MADDR, W_DEC, W_FETCH}},
    '{6'b000100, 1'b1, 3'd3, {W_Z,   W_Z,   W_BEQ,   W_DEC, W_FETCH}},
    '{6'b000010, 1'b1, 3'd3, {W_Z,   W_Z,   W_JMP,   W_DEC, W_FETCH}},
    '{6'b000001, 1'b1, 3'd3, {W_Z,   W_Z,   W_EXU,   W_DEC, W_FETCH}},
    '{6'b000000, 1'b0, 3'd4, {W_Z,   W_RDN, W_REX,   W_DEC, W_FETCH}}
  };

  function automatic logic [18:0] actual_word();
    return {pc_we_o, pc_we_cond_o, mem_addr_sel_o, mem_rd_o, mem_wr_o, instr_we_o,
            wb_sel_mem_o, pc_sel_o, alu_mode_o, alu_a_sel_o, alu_b_sel_o,
            rf_we_o, rf_dst_rd_o, fault_pc_we_o, fault_code_we_o, fault_code_o};
  endfunction

  function automatic string row_tag(int i);
    case (i)
      0, 12:  return "R4";
      1:      return "R5";
      2:      return "R6";
      3:      return "R7";
      4:      return "R8";
      5, 11:  return "R9";
      6:      return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, int row, int cyc, logic [18:0] exp);
    logic [18:0] act;
    act = actual_word();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s row %0d cycle %0d actual=%b expected=%b", tag, row, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    // R1: outputs during reset
    #3;
    check("R1", -1, 0, W_FETCH);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", -1, 1, W_FETCH);

    for (int i = 0; i < NVEC; i++) begin
      opcode_i   = TBL[i].op;
      overflow_i = TBL[i].ovf;
      for (int k = 0; k < int'(TBL[i].len); k++) begin
        if (k == 0)      check((i == 0) ? "R2" : "R12", i, k, TBL[i].w[k]);
        else if (k == 1) check("R3", i, k, TBL[i].w[k]);
        else             check(row_tag(i), i, k, TBL[i].w[k]);
        @(negedge clk_i);
        #1;
      end
    end

    // R12: fetch again after the last completion
    check("R12", NVEC, 0, W_FETCH);

    // R1: asynchronous reset in the middle of a load
    opcode_i   = 6'b100011;
    overflow_i = 1'b0;
    @(negedge clk_i); #1;
    check("R3", 100, 1, W_DEC);
    @(negedge clk_i); #1;
    check("R5", 100, 2, W_MADDR);
    rst_ni = 1'b0;
    #1;
    check("R1", 100, 3, W_FETCH);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", 100, 4, W_FETCH);
    @(negedge clk_i); #1;
    check("R3", 100, 5, W_DEC);

    // R11: overflow held through a branch after reset is ignored
    opcode_i   = 6'b000100;
    overflow_i = 1'b1;
    @(negedge clk_i); #1;
    check("R11", 101, 2, W_BEQ);
    @(negedge clk_i); #1;
    check("R12", 101, 3, W_FETCH);

    finish_run();
  end

endmodule